// File: doc/BRIEF.md
# Ping-Pong Packet Transmit Buffer

This block holds outgoing packets for one bulk-style transmit endpoint. Its storage is split into two halves of one maximum-size packet each. Software fills one half while the transmit side drains the other. The fill side takes 32-bit words from the CPU or single bytes from a DMA engine. A commit strobe seals the half being filled, records how many bytes it holds, and moves filling to the opposite half.

The transmit side always sees the oldest sealed packet. It reads that packet one byte at a time by pulsing a read strobe. When the host has accepted the packet, a release strobe frees the half and exposes the next sealed packet, if one exists. When both halves are sealed, the block reports itself full and drops further writes and commits. A clear input returns the buffer to empty. The stored bytes themselves are not reset.

Top module: `pp_tx_buf`

## Requirements
- R1: After reset, `tx_avail_o` and `full_o` are 0.
- R2: A CPU word write stores `cpu_wdata_i[7:0]` at the fill pointer, `[15:8]` at the pointer plus 1, `[23:16]` at plus 2 and `[31:24]` at plus 3. It then advances the fill pointer by 4. The pointer need not be word aligned.
- R3: A DMA write stores `dma_wdata_i` at the fill pointer and advances the pointer by 1.
- R4: When `cpu_we_i` and `dma_we_i` are both high in one cycle, only the CPU write is considered. The DMA byte is discarded.
- R5: Bytes written into the fill half are not offered to the transmit side until a commit. `tx_avail_o` stays 0 while only writes occur.
- R6: An accepted commit seals the fill half. Its length is the number of bytes written, including any write accepted in the same cycle. Filling then moves to the other half, starting at pointer 0.
- R7: While a packet is available, `tx_data_o` shows the byte at the read pointer and `tx_rd_i` advances that pointer. `tx_end_o` is 1 once the pointer equals `tx_len_o`. A read at that point changes nothing.
- R8: Packets drain oldest first. `tx_ack_i` frees the half being drained and exposes the other half if it is sealed.
- R9: `full_o` is 1 exactly when both halves are sealed. While it is 1, writes and commits are ignored.
- R10: A CPU word write that would not fit entirely in the 64 bytes remaining in the half is ignored. A DMA write is ignored once the half holds 64 bytes.
- R11: A commit with no bytes written produces an available packet with `tx_len_o` = 0 and `tx_end_o` = 1.
- R12: A release and a commit in the same cycle both take effect.
- R13: `clr_i` overrides every other input. It empties both halves and discards a partly filled packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous flush of both halves |
| cpu_we_i | input | 1 | CPU word write strobe |
| cpu_wdata_i | input | 32 | CPU write word, little-endian |
| dma_we_i | input | 1 | DMA byte write strobe |
| dma_wdata_i | input | 8 | DMA write byte |
| commit_i | input | 1 | Seal the fill half as a packet |
| tx_rd_i | input | 1 | Advance the read pointer |
| tx_ack_i | input | 1 | Release the drained half |
| tx_avail_o | output | 1 | A sealed packet is offered |
| tx_data_o | output | 8 | Byte at the read pointer |
| tx_len_o | output | 7 | Length of the offered packet |
| tx_end_o | output | 1 | All bytes of the offered packet have been read |
| full_o | output | 1 | Both halves are sealed |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a fill-side commit and a drain-side release. The bench provokes this by leaving one packet pending, writing into the other half, and then raising `tx_ack_i`, `commit_i` and a DMA byte together. It judges the result by the offered length and bytes: the new packet must carry the same-cycle byte, and the old packet must be gone. The second pair is simultaneous CPU and DMA writes. The bench judges this by the committed length of 4 and the absence of the DMA byte.

// File: rtl/pp_tx_pkg.sv
`timescale 1ns/1ps
package pp_tx_pkg;
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_BYTE = 2'd1,
    WR_WORD = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/pp_tx_wr_pack.sv
`timescale 1ns/1ps
module pp_tx_wr_pack
  import pp_tx_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int CPU_W     = 32,
  localparam int LANES    = CPU_W / 8,
  localparam int CW       = $clog2(PKT_BYTES + 1)
) (
  input  logic             cpu_we_i,
  input  logic [CPU_W-1:0] cpu_wdata_i,
  input  logic             dma_we_i,
  input  logic [7:0]       dma_wdata_i,
  input  logic             blocked_i,
  input  logic [CW-1:0]    wptr_i,
  output wr_kind_e         kind_o,
  output logic [LANES-1:0] be_o,
  output logic [CPU_W-1:0] data_o,
  output logic [CW-1:0]    step_o
);
  logic [CW-1:0] room;
  assign room = CW'(PKT_BYTES) - wptr_i;

  // CPU strobe wins even when its own write is dropped
  always_comb begin
    kind_o = WR_NONE;
    if (!blocked_i) begin
      if (cpu_we_i) begin
        if (room >= CW'(LANES)) kind_o = WR_WORD;
      end else if (dma_we_i && room != '0) begin
        kind_o = WR_BYTE;
      end
    end
  end

  always_comb begin
    be_o   = '0;
    data_o = '0;
    step_o = '0;
    case (kind_o)
      WR_WORD: begin
        be_o   = '1;
        data_o = cpu_wdata_i;
        step_o = CW'(LANES);
      end
      WR_BYTE: begin
        be_o[0]     = 1'b1;
        data_o[7:0] = dma_wdata_i;
        step_o      = CW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pp_tx_store.sv
`timescale 1ns/1ps
module pp_tx_store #(
  parameter int DEPTH  = 128,
  parameter int LANES  = 4,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic [IW-1:0]      wbase_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [LANES*8-1:0] wdata_i,
  input  logic [IW-1:0]      raddr_i,
  output logic [7:0]         rdata_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [IW-1:0] lane_addr [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_addr[l] = wbase_i + IW'(l);
  end

  // contents intentionally not reset
  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (be_i[l]) mem_q[lane_addr[l]] <= wdata_i[8*l +: 8];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pp_tx_ctrl.sv
`timescale 1ns/1ps
module pp_tx_ctrl #(
  parameter int PKT_BYTES = 64,
  localparam int CW       = $clog2(PKT_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [CW-1:0] step_i,
  input  logic          commit_i,
  input  logic          rd_i,
  input  logic          ack_i,
  output logic          fill_sel_o,
  output logic [CW-1:0] wptr_o,
  output logic          drain_sel_o,
  output logic [CW-1:0] rptr_o,
  output logic          avail_o,
  output logic [CW-1:0] len_o,
  output logic          end_o,
  output logic          full_o
);
  logic [1:0]    valid_q;
  logic [CW-1:0] len_q [2];
  logic          fill_q, drain_q;
  logic [CW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] wptr_nxt;
  logic          commit_ok;

  assign wptr_nxt  = wptr_q + step_i;
  assign commit_ok = commit_i && !valid_q[fill_q];
  assign avail_o   = valid_q[drain_q];
  assign full_o    = &valid_q;
  assign len_o     = len_q[drain_q];
  assign end_o     = avail_o && (rptr_q == len_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
      fill_q   <= 1'b0;
      drain_q  <= 1'b0;
      wptr_q   <= '0;
      rptr_q   <= '0;
    end else if (clr_i) begin
      valid_q <= '0;
      fill_q  <= 1'b0;
      drain_q <= 1'b0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else begin
      if (commit_ok) begin
        valid_q[fill_q] <= 1'b1;
        len_q[fill_q]   <= wptr_nxt;
        fill_q          <= ~fill_q;
        wptr_q          <= '0;
      end else begin
        wptr_q <= wptr_nxt;
      end
      // drain half differs from fill half whenever both act
      if (ack_i && avail_o) begin
        valid_q[drain_q] <= 1'b0;
        drain_q          <= ~drain_q;
        rptr_q           <= '0;
      end else if (rd_i && avail_o && !end_o) begin
        rptr_q <= rptr_q + CW'(1);
      end
    end
  end

  assign fill_sel_o  = fill_q;
  assign wptr_o      = wptr_q;
  assign drain_sel_o = drain_q;
  assign rptr_o      = rptr_q;
endmodule

// File: rtl/pp_tx_buf.sv
`timescale 1ns/1ps
module pp_tx_buf
  import pp_tx_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int CPU_W     = 32,
  localparam int LANES    = CPU_W / 8,
  localparam int CW       = $clog2(PKT_BYTES + 1),
  localparam int AW       = $clog2(PKT_BYTES),
  localparam int DEPTH    = 2 * PKT_BYTES,
  localparam int IW       = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cpu_we_i,
  input  logic [CPU_W-1:0] cpu_wdata_i,
  input  logic             dma_we_i,
  input  logic [7:0]       dma_wdata_i,
  input  logic             commit_i,
  input  logic             tx_rd_i,
  input  logic             tx_ack_i,
  output logic             tx_avail_o,
  output logic [7:0]       tx_data_o,
  output logic [CW-1:0]    tx_len_o,
  output logic             tx_end_o,
  output logic             full_o
);
  wr_kind_e         kind;
  logic [LANES-1:0] be;
  logic [CPU_W-1:0] lane_data;
  logic [CW-1:0]    step, wptr, rptr;
  logic             fill_sel, drain_sel;

  // fill half is sealed only when both are
  pp_tx_wr_pack #(.PKT_BYTES(PKT_BYTES), .CPU_W(CPU_W)) u_pack (
    .cpu_we_i   (cpu_we_i),
    .cpu_wdata_i(cpu_wdata_i),
    .dma_we_i   (dma_we_i),
    .dma_wdata_i(dma_wdata_i),
    .blocked_i  (full_o),
    .wptr_i     (wptr),
    .kind_o     (kind),
    .be_o       (be),
    .data_o     (lane_data),
    .step_o     (step)
  );

  pp_tx_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .step_i     (clr_i ? '0 : step),
    .commit_i   (commit_i),
    .rd_i       (tx_rd_i),
    .ack_i      (tx_ack_i),
    .fill_sel_o (fill_sel),
    .wptr_o     (wptr),
    .drain_sel_o(drain_sel),
    .rptr_o     (rptr),
    .avail_o    (tx_avail_o),
    .len_o      (tx_len_o),
    .end_o      (tx_end_o),
    .full_o     (full_o)
  );

  pp_tx_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk_i  (clk_i),
    .wbase_i({fill_sel, wptr[AW-1:0]}),
    .be_i   (clr_i ? '0 : be),
    .wdata_i(lane_data),
    .raddr_i({drain_sel, rptr[AW-1:0]}),
    .rdata_o(tx_data_o)
  );
endmodule

// File: rtl/pp_tx_buf_chk.sv
`timescale 1ns/1ps
module pp_tx_buf_chk #(
  parameter int PKT_BYTES = 64,
  parameter int CPU_W     = 32,
  localparam int CW       = $clog2(PKT_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             cpu_we_i,
  input logic [CPU_W-1:0] cpu_wdata_i,
  input logic             dma_we_i,
  input logic [7:0]       dma_wdata_i,
  input logic             commit_i,
  input logic             tx_rd_i,
  input logic             tx_ack_i,
  input logic             tx_avail_o,
  input logic [7:0]       tx_data_o,
  input logic [CW-1:0]    tx_len_o,
  input logic             tx_end_o,
  input logic             full_o
);
  // R9
  full_implies_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> tx_avail_o);

  // R13
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!tx_avail_o && !full_o));

  // R5
  no_commit_no_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_avail_o && !commit_i) |=> !tx_avail_o);

  // R8
  release_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ack_i && tx_avail_o && !full_o && !commit_i && !clr_i) |=> !tx_avail_o);

  // R6
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_avail_o && !tx_ack_i && !clr_i) |=> $stable(tx_len_o));

  // R11
  zero_len_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_avail_o && tx_len_o == '0) |-> tx_end_o);

  // R7
  end_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_end_o && !tx_ack_i && !clr_i) |=> tx_end_o);
endmodule

bind pp_tx_buf pp_tx_buf_chk #(.PKT_BYTES(PKT_BYTES), .CPU_W(CPU_W)) u_chk (.*);

// File: tb/tb_pp_tx_buf.sv
`timescale 1ns/1ps
module tb_pp_tx_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 0, cpu_we = 0, dma_we = 0, commit = 0, rd = 0, ack = 0;
  logic [31:0] cpu_wdata = '0;
  logic [7:0]  dma_wdata = '0;
  logic        avail, tend, full;
  logic [7:0]  tdata;
  logic [6:0]  tlen;
  int          n_chk = 0, n_err = 0;
  logic [7:0]  exp_b [64];

  always #4 clk = ~clk;

  pp_tx_buf dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wdata),
    .dma_we_i(dma_we), .dma_wdata_i(dma_wdata),
    .commit_i(commit), .tx_rd_i(rd), .tx_ack_i(ack),
    .tx_avail_o(avail), .tx_data_o(tdata), .tx_len_o(tlen),
    .tx_end_o(tend), .full_o(full)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_word(input logic [31:0] w);
    cpu_we = 1; cpu_wdata = w; cyc(); cpu_we = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    dma_we = 1; dma_wdata = b; cyc(); dma_we = 0;
  endtask

  task automatic do_commit();
    commit = 1; cyc(); commit = 0;
  endtask

  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic drain(input int n, input string tag);
    chk(avail === 1'b1, {tag, " avail"}, 32'(avail), 1);
    chk(tlen === 7'(n), {tag, " len"}, 32'(tlen), 32'(n));
    for (int i = 0; i < n; i++) begin
      chk(tdata === exp_b[i], {tag, " data"}, 32'(tdata), 32'(exp_b[i]));
      chk(tend === 1'b0, {tag, " end early"}, 32'(tend), 0);
      rd = 1; cyc(); rd = 0;
    end
    chk(tend === 1'b1, {tag, " end"}, 32'(tend), 1);
  endtask

  task automatic t_reset();
    chk(avail === 1'b0, "R1 avail", 32'(avail), 0);
    chk(full === 1'b0, "R1 full", 32'(full), 0);
  endtask

  task automatic t_word();
    wr_word(32'h44332211);
    wr_word(32'h88776655);
    chk(avail === 1'b0, "R5 hidden", 32'(avail), 0);
    do_commit();
    for (int i = 0; i < 8; i++) exp_b[i] = 8'(8'h11 * (i + 1));
    drain(8, "R2 R6 word");
    do_ack();
    chk(avail === 1'b0, "R8 released", 32'(avail), 0);
  endtask

  task automatic t_dma();
    for (int i = 0; i < 5; i++) begin
      wr_byte(8'(8'hA0 + i));
      exp_b[i] = 8'(8'hA0 + i);
    end
    wr_word(32'hDDCCBBAA);
    exp_b[5] = 8'hAA; exp_b[6] = 8'hBB; exp_b[7] = 8'hCC; exp_b[8] = 8'hDD;
    do_commit();
    drain(9, "R3 dma+unaligned");
    do_ack();
  endtask

  task automatic t_prio();
    cpu_we = 1; cpu_wdata = 32'h04030201; dma_we = 1; dma_wdata = 8'hEE;
    cyc();
    cpu_we = 0; dma_we = 0;
    do_commit();
    for (int i = 0; i < 4; i++) exp_b[i] = 8'(i + 1);
    drain(4, "R4 prio");
    do_ack();
  endtask

  task automatic t_zero();
    do_commit();
    chk(avail === 1'b1, "R11 avail", 32'(avail), 1);
    chk(tlen === 7'd0, "R11 len", 32'(tlen), 0);
    chk(tend === 1'b1, "R11 end", 32'(tend), 1);
    do_ack();
    chk(avail === 1'b0, "R11 released", 32'(avail), 0);
  endtask

  task automatic t_full();
    wr_byte(8'h10); do_commit();
    chk(full === 1'b0, "R9 one sealed", 32'(full), 0);
    wr_byte(8'h20); do_commit();
    chk(full === 1'b1, "R9 full", 32'(full), 1);
    wr_word(32'hDEADBEEF);
    wr_byte(8'h99);
    do_commit();
    chk(full === 1'b1, "R9 still full", 32'(full), 1);
    exp_b[0] = 8'h10;
    drain(1, "R8 oldest");
    do_ack();
    chk(full === 1'b0, "R9 freed", 32'(full), 0);
    exp_b[0] = 8'h20;
    drain(1, "R8 second");
    wr_byte(8'h30); do_commit();
    do_ack();
    exp_b[0] = 8'h30;
    drain(1, "R9 ignored writes");
    do_ack();
  endtask

  task automatic t_ovf();
    for (int i = 0; i < 63; i++) begin
      wr_byte(8'(i));
      exp_b[i] = 8'(i);
    end
    wr_word(32'h55555555);
    wr_byte(8'hFF);
    exp_b[63] = 8'hFF;
    wr_byte(8'h77);
    do_commit();
    drain(64, "R10 overflow");
    rd = 1; cyc(); rd = 0;
    chk(tend === 1'b1, "R7 read past end", 32'(tend), 1);
    do_ack();
  endtask

  task automatic t_same();
    wr_byte(8'h51); wr_byte(8'h52); do_commit();
    wr_byte(8'h61);
    dma_we = 1; dma_wdata = 8'h62; commit = 1; ack = 1;
    cyc();
    dma_we = 0; commit = 0; ack = 0;
    chk(full === 1'b0, "R12 not full", 32'(full), 0);
    exp_b[0] = 8'h61; exp_b[1] = 8'h62;
    drain(2, "R12 ack+commit");
    do_ack();
  endtask

  task automatic t_clr();
    wr_byte(8'h01); do_commit();
    wr_word(32'h0A0B0C0D);
    clr = 1; commit = 1; ack = 1; cyc();
    clr = 0; commit = 0; ack = 0;
    chk(avail === 1'b0, "R13 avail", 32'(avail), 0);
    chk(full === 1'b0, "R13 full", 32'(full), 0);
    wr_byte(8'h77); do_commit();
    exp_b[0] = 8'h77;
    drain(1, "R13 partial dropped");
    do_ack();
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_word();
    t_dma();
    t_prio();
    t_zero();
    t_full();
    t_ovf();
    t_same();
    t_clr();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule